// File: doc/BRIEF.md
# Initialization-Time Target Response Gate

This block sits between a bus target's normal address decode and its bus-side response pins. While the local side of the device is still initializing, it decides how the target answers an access. It has two policies. Under the silent policy the target never claims the access, so the requester times out with a master abort. Under the retry policy the target claims the access and ends it at once with a retry. A mode strap selects the policy. The strap is captured when reset is released and keeps its effect until the next reset. After that capture the strap pin serves only as a general-purpose input level.

Initialization counts as finished when the done bit of a local control register is 1. Three sources can set that bit:

- a local-side write that carries a 1 in the bit;
- a configuration image loaded from a serial memory that carries a 1 in the bit;
- a fallback that fires when no local master is fitted and the serial memory is either missing or blank. A blank memory is one whose first word is all ones.

Only reset clears the bit. Once the bit is set, the response of the normal decode path goes straight to the pins with no added delay. The serial memory reader and the full bus protocol lie outside the block. They reach it as simple pulse and level inputs.

Top module: `igate_top`

## Requirements
- R1: The strap level present on the last clock edge with `rst` high is held as the policy until the next reset. Changing the pin after reset has no effect on the policy.
- R2: With a low strap and the done bit clear, `tgt_devsel`, `tgt_trdy` and `tgt_stop` stay 0 for every access (master abort).
- R3: With a high strap and the done bit clear, an `acc_req` pulse gives, one cycle later, exactly one cycle of `tgt_devsel`=1, `tgt_stop`=1, `tgt_trdy`=0 (retry).
- R4: A local write with `loc_wr_addr`=MISC_ADDR loads the whole control register. Bit 2 is the done bit. When it is 1, `init_done` is 1 on the next cycle. A write to any other address changes neither the register nor `init_done`.
- R5: Writing 0 to bit 2 while it is set leaves it set. The other bits of the register take the written value.
- R6: An `ee_done` pulse with `ee_present`=1 and `ee_first_word` not all ones copies `ee_misc_image` into the register. `init_done` follows the image's bit 2.
- R7: An `ee_done` pulse with `loc_master_present`=0, and either `ee_present`=0 or `ee_first_word` all ones, sets bit 2. The other bits keep their reset defaults (MISC_RST).
- R8: An `ee_done` pulse with a blank or missing memory while `loc_master_present`=1 changes nothing.
- R9: While `init_done` is 1, `{tgt_devsel,tgt_trdy,tgt_stop}` equals `{dec_devsel,dec_trdy,dec_stop}` in the same cycle, and no retry or suppression occurs.
- R10: `gpi_level` shows the strap pin level two clock edges after it changes, in every state.
- R11: During reset, `init_done`=0, the response outputs are 0 and `misc_rd` equals MISC_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_strap | input | 1 | Policy strap; general-purpose level after reset |
| acc_req | input | 1 | One-cycle pulse marking the start of a bus access |
| dec_devsel | input | 1 | Device-select from the normal decode path |
| dec_trdy | input | 1 | Target-ready from the normal decode path |
| dec_stop | input | 1 | Stop from the normal decode path |
| loc_wr_en | input | 1 | Local register write strobe |
| loc_wr_addr | input | ADDR_W | Local register write address |
| loc_wr_data | input | DATA_W | Local register write data |
| loc_master_present | input | 1 | A local bus master is fitted |
| ee_done | input | 1 | One-cycle pulse when the serial memory read ends |
| ee_present | input | 1 | A serial memory answered |
| ee_first_word | input | DATA_W | First word read from the serial memory |
| ee_misc_image | input | DATA_W | Image value for the control register |
| tgt_devsel | output | 1 | Device-select to the bus |
| tgt_trdy | output | 1 | Target-ready to the bus |
| tgt_stop | output | 1 | Stop to the bus |
| init_done | output | 1 | Local initialization complete |
| misc_rd | output | DATA_W | Control register read value |
| gpi_level | output | 1 | Synchronized strap pin level |

## Verification
A wrong captured policy shows on the first access after reset. A missing retry or a spurious device-select appears one cycle after `acc_req`. A done bit that is lost or set too early shows on `init_done` and `misc_rd` on the cycle after the write or load pulse that caused it. It also shows on the response pins of the next access. A stale passthrough shows in the same cycle as the decode pattern that exposes it.

// File: rtl/igate_pkg.sv
package igate_pkg;

    localparam int DATA_W_DEF = 32;
    localparam int ADDR_W_DEF = 8;
    localparam int DONE_BIT_DEF = 2;

    typedef struct packed {
        logic devsel;
        logic trdy;
        logic stop;
    } tresp_t;

    localparam tresp_t RESP_IDLE  = '{devsel: 1'b0, trdy: 1'b0, stop: 1'b0};
    localparam tresp_t RESP_RETRY = '{devsel: 1'b1, trdy: 1'b0, stop: 1'b1};

    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_LOCAL    = 2'd1,
        SRC_EEPROM   = 2'd2,
        SRC_FALLBACK = 2'd3
    } set_src_e;

    function automatic tresp_t pick_resp(input logic done, input logic retry_now,
                                         input tresp_t normal);
        tresp_t r;
        if (done)           r = normal;
        else if (retry_now) r = RESP_RETRY;
        else                r = RESP_IDLE;
        return r;
    endfunction

endpackage

// File: rtl/igate_strap.sv
module igate_strap (
    input  logic clk,
    input  logic rst,
    input  logic strap_pin,
    output logic strap_q,
    output logic gpi_level
);
    logic sync1_q;

    // Tracks the pin while reset is held, freezes at release.
    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_pin;
    end

    always_ff @(posedge clk) begin
        sync1_q   <= strap_pin;
        gpi_level <= sync1_q;
    end
endmodule

// File: rtl/igate_misc_reg.sv
module igate_misc_reg
    import igate_pkg::*;
#(
    parameter int DATA_W    = DATA_W_DEF,
    parameter int ADDR_W    = ADDR_W_DEF,
    parameter int DONE_BIT  = DONE_BIT_DEF,
    parameter logic [ADDR_W-1:0] MISC_ADDR = 'h0C,
    parameter logic [DATA_W-1:0] MISC_RST  = 'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loc_wr_en,
    input  logic [ADDR_W-1:0] loc_wr_addr,
    input  logic [DATA_W-1:0] loc_wr_data,
    input  logic              loc_master_present,
    input  logic              ee_done,
    input  logic              ee_present,
    input  logic [DATA_W-1:0] ee_first_word,
    input  logic [DATA_W-1:0] ee_misc_image,
    output logic [DATA_W-1:0] misc_q,
    output logic              init_done
);
    logic     hit_local;
    logic     ee_blank;
    logic     ee_load;
    logic     ee_fallback;
    set_src_e data_src;
    logic [DATA_W-1:0] body_next;
    logic              done_next;

    assign hit_local   = loc_wr_en && (loc_wr_addr == MISC_ADDR);
    assign ee_blank    = &ee_first_word;
    assign ee_load     = ee_done && ee_present && !ee_blank;
    assign ee_fallback = ee_done && !loc_master_present && (!ee_present || ee_blank);

    always_comb begin
        if (hit_local)        data_src = SRC_LOCAL;
        else if (ee_load)     data_src = SRC_EEPROM;
        else if (ee_fallback) data_src = SRC_FALLBACK;
        else                  data_src = SRC_NONE;
    end

    always_comb begin
        body_next = misc_q;
        done_next = misc_q[DONE_BIT];
        unique case (data_src)
            SRC_LOCAL:    body_next = loc_wr_data;
            SRC_EEPROM:   body_next = ee_misc_image;
            SRC_FALLBACK: body_next = misc_q;
            default:      body_next = misc_q;
        endcase
        done_next = misc_q[DONE_BIT]
                  | (hit_local && loc_wr_data[DONE_BIT])
                  | (ee_load && ee_misc_image[DONE_BIT])
                  | ee_fallback;
        body_next[DONE_BIT] = done_next;
    end

    always_ff @(posedge clk) begin
        if (rst) misc_q <= MISC_RST;
        else     misc_q <= body_next;
    end

    assign init_done = misc_q[DONE_BIT];
endmodule

// File: rtl/igate_resp.sv
module igate_resp
    import igate_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   strap_q,
    input  logic   init_done,
    input  logic   acc_req,
    input  tresp_t normal,
    output tresp_t resp
);
    logic retry_q;

    always_ff @(posedge clk) begin
        if (rst) retry_q <= 1'b0;
        else     retry_q <= acc_req && strap_q && !init_done;
    end

    assign resp = pick_resp(init_done, retry_q, normal);
endmodule

// File: rtl/igate_top.sv
module igate_top
    import igate_pkg::*;
#(
    parameter int DATA_W   = DATA_W_DEF,
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int DONE_BIT = DONE_BIT_DEF,
    parameter logic [ADDR_W-1:0] MISC_ADDR = 'h0C,
    parameter logic [DATA_W-1:0] MISC_RST  = 'h1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_strap,
    input  logic              acc_req,
    input  logic              dec_devsel,
    input  logic              dec_trdy,
    input  logic              dec_stop,
    input  logic              loc_wr_en,
    input  logic [ADDR_W-1:0] loc_wr_addr,
    input  logic [DATA_W-1:0] loc_wr_data,
    input  logic              loc_master_present,
    input  logic              ee_done,
    input  logic              ee_present,
    input  logic [DATA_W-1:0] ee_first_word,
    input  logic [DATA_W-1:0] ee_misc_image,
    output logic              tgt_devsel,
    output logic              tgt_trdy,
    output logic              tgt_stop,
    output logic              init_done,
    output logic [DATA_W-1:0] misc_rd,
    output logic              gpi_level
);
    logic   strap_q;
    tresp_t normal;
    tresp_t resp;

    igate_strap u_strap (
        .clk       (clk),
        .rst       (rst),
        .strap_pin (mode_strap),
        .strap_q   (strap_q),
        .gpi_level (gpi_level)
    );

    igate_misc_reg #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .DONE_BIT  (DONE_BIT),
        .MISC_ADDR (MISC_ADDR),
        .MISC_RST  (MISC_RST)
    ) u_misc (
        .clk                (clk),
        .rst                (rst),
        .loc_wr_en          (loc_wr_en),
        .loc_wr_addr        (loc_wr_addr),
        .loc_wr_data        (loc_wr_data),
        .loc_master_present (loc_master_present),
        .ee_done            (ee_done),
        .ee_present         (ee_present),
        .ee_first_word      (ee_first_word),
        .ee_misc_image      (ee_misc_image),
        .misc_q             (misc_rd),
        .init_done          (init_done)
    );

    assign normal = '{devsel: dec_devsel, trdy: dec_trdy, stop: dec_stop};

    igate_resp u_resp (
        .clk       (clk),
        .rst       (rst),
        .strap_q   (strap_q),
        .init_done (init_done),
        .acc_req   (acc_req),
        .normal    (normal),
        .resp      (resp)
    );

    assign tgt_devsel = resp.devsel;
    assign tgt_trdy   = resp.trdy;
    assign tgt_stop   = resp.stop;
endmodule

// File: rtl/igate_chk.sv
module igate_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int DONE_BIT = 2,
    parameter logic [ADDR_W-1:0] MISC_ADDR = 'h0C
) (
    input logic              clk,
    input logic              rst,
    input logic              strap_q,
    input logic              acc_req,
    input logic              loc_wr_en,
    input logic [ADDR_W-1:0] loc_wr_addr,
    input logic [DATA_W-1:0] loc_wr_data,
    input logic              dec_devsel,
    input logic              dec_trdy,
    input logic              dec_stop,
    input logic              tgt_devsel,
    input logic              tgt_trdy,
    input logic              tgt_stop,
    input logic              init_done
);
    p_strap_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(strap_q));

    p_silent_r2: assert property (@(posedge clk) disable iff (rst)
        (!strap_q && !init_done) |-> (!tgt_devsel && !tgt_trdy && !tgt_stop));

    p_retry_r3: assert property (@(posedge clk) disable iff (rst)
        (strap_q && !init_done && acc_req) |=>
        (init_done || (tgt_devsel && tgt_stop && !tgt_trdy)));

    p_local_set_r4: assert property (@(posedge clk) disable iff (rst)
        (loc_wr_en && loc_wr_addr == MISC_ADDR && loc_wr_data[DONE_BIT]) |=> init_done);

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    p_pass_r9: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (tgt_devsel == dec_devsel && tgt_trdy == dec_trdy
                       && tgt_stop == dec_stop));
endmodule

bind igate_top igate_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .DONE_BIT  (DONE_BIT),
    .MISC_ADDR (MISC_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .strap_q     (strap_q),
    .acc_req     (acc_req),
    .loc_wr_en   (loc_wr_en),
    .loc_wr_addr (loc_wr_addr),
    .loc_wr_data (loc_wr_data),
    .dec_devsel  (dec_devsel),
    .dec_trdy    (dec_trdy),
    .dec_stop    (dec_stop),
    .tgt_devsel  (tgt_devsel),
    .tgt_trdy    (tgt_trdy),
    .tgt_stop    (tgt_stop),
    .init_done   (init_done)
);

// File: tb/igate_top_tb_top.sv
`timescale 1ns/1ps
module igate_top_tb_top;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam logic [AW-1:0] MADDR = 8'h0C;
    localparam logic [DW-1:0] MRST  = 32'h0000_0001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_strap = 1'b0;
    logic acc_req = 1'b0;
    logic dec_devsel = 1'b0, dec_trdy = 1'b0, dec_stop = 1'b0;
    logic loc_wr_en = 1'b0;
    logic [AW-1:0] loc_wr_addr = '0;
    logic [DW-1:0] loc_wr_data = '0;
    logic loc_master_present = 1'b1;
    logic ee_done = 1'b0, ee_present = 1'b0;
    logic [DW-1:0] ee_first_word = '0, ee_misc_image = '0;
    logic tgt_devsel, tgt_trdy, tgt_stop, init_done, gpi_level;
    logic [DW-1:0] misc_rd;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    igate_top #(.DATA_W(DW), .ADDR_W(AW), .MISC_ADDR(MADDR), .MISC_RST(MRST)) dut_i (
        .clk(clk), .rst(rst), .mode_strap(mode_strap), .acc_req(acc_req),
        .dec_devsel(dec_devsel), .dec_trdy(dec_trdy), .dec_stop(dec_stop),
        .loc_wr_en(loc_wr_en), .loc_wr_addr(loc_wr_addr), .loc_wr_data(loc_wr_data),
        .loc_master_present(loc_master_present), .ee_done(ee_done),
        .ee_present(ee_present), .ee_first_word(ee_first_word),
        .ee_misc_image(ee_misc_image), .tgt_devsel(tgt_devsel), .tgt_trdy(tgt_trdy),
        .tgt_stop(tgt_stop), .init_done(init_done), .misc_rd(misc_rd),
        .gpi_level(gpi_level)
    );

    // Passthrough vectors: {devsel,trdy,stop} from decode; expected equal at pins.
    typedef struct packed { logic [2:0] dec; logic [2:0] exp; } vec_t;
    localparam vec_t VECS [8] = '{
        '{3'b000, 3'b000}, '{3'b100, 3'b100}, '{3'b110, 3'b110}, '{3'b101, 3'b101},
        '{3'b001, 3'b001}, '{3'b010, 3'b010}, '{3'b111, 3'b111}, '{3'b011, 3'b011}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pins();
        return {29'd0, tgt_devsel, tgt_trdy, tgt_stop};
    endfunction

    task automatic do_reset(input logic strap);
        rst = 1'b1;
        mode_strap = strap;
        repeat (3) tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic lwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
        loc_wr_en = 1'b1; loc_wr_addr = a; loc_wr_data = d;
        tick();
        loc_wr_en = 1'b0;
    endtask

    task automatic ee_pulse(input logic pres, input logic [DW-1:0] fw, input logic [DW-1:0] img);
        ee_done = 1'b1; ee_present = pres; ee_first_word = fw; ee_misc_image = img;
        tick();
        ee_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        mode_strap = 1'b1;
        repeat (3) tick();
        // R11 reset state
        chk("R11 init_done in reset", {31'd0, init_done}, 0);
        chk("R11 pins in reset", pins(), 0);
        chk("R11 misc default", misc_rd, MRST);
        rst = 1'b0;
        tick();

        // R1: strap captured high; pin now low
        mode_strap = 1'b0;
        tick(); tick();
        chk("R10 gpi follows pin low", {31'd0, gpi_level}, 0);
        mode_strap = 1'b1; tick(); tick();
        chk("R10 gpi follows pin high", {31'd0, gpi_level}, 1);
        mode_strap = 1'b0; tick();
        // R3 retry, policy unchanged by pin (R1)
        acc_req = 1'b1; dec_devsel = 1'b1; dec_trdy = 1'b1;
        tick();
        acc_req = 1'b0;
        chk("R3 R1 retry response", pins(), 32'b101);
        tick();
        chk("R3 retry lasts one cycle", pins(), 0);
        dec_devsel = 1'b0; dec_trdy = 1'b0;

        // R4: other address ignored
        lwrite(MADDR + 8'h4, 32'hFFFF_FFFF);
        chk("R4 other addr init_done", {31'd0, init_done}, 0);
        chk("R4 other addr misc", misc_rd, MRST);

        // R8: blank memory while master present
        loc_master_present = 1'b1;
        ee_pulse(1'b1, 32'hFFFF_FFFF, 32'h0000_0004);
        chk("R8 blank with master", misc_rd, MRST);
        ee_pulse(1'b0, 32'h0, 32'h0000_0004);
        chk("R8 absent with master", {31'd0, init_done}, 0);

        // R6: valid image with bit2 clear
        ee_pulse(1'b1, 32'h1234_0000, 32'hA5A5_0000);
        chk("R6 image loaded", misc_rd, 32'hA5A5_0000);
        chk("R6 bit2 clear not done", {31'd0, init_done}, 0);

        // R4: local write sets
        lwrite(MADDR, 32'h1234_5674);
        chk("R4 local set done", {31'd0, init_done}, 1);
        chk("R4 local data", misc_rd, 32'h1234_5674);

        // R5: write 0 to bit2 does not clear
        lwrite(MADDR, 32'hFFFF_FFF0);
        chk("R5 sticky bit", misc_rd, 32'hFFFF_FFF4);

        // R9 passthrough vectors, with accesses
        foreach (VECS[i]) begin
            acc_req = i[0];
            {dec_devsel, dec_trdy, dec_stop} = VECS[i].dec;
            tick();
            chk($sformatf("R9 vector %0d", i), pins(), {29'd0, VECS[i].exp});
        end
        acc_req = 1'b0; {dec_devsel, dec_trdy, dec_stop} = 3'b000;

        // R11 reset clears done; R2 silent policy
        do_reset(1'b0);
        chk("R11 reset clears done", {31'd0, init_done}, 0);
        mode_strap = 1'b1;
        acc_req = 1'b1; dec_devsel = 1'b1; dec_stop = 1'b1;
        tick();
        acc_req = 1'b0;
        chk("R2 silent cycle1", pins(), 0);
        tick();
        chk("R2 silent cycle2", pins(), 0);
        dec_devsel = 1'b0; dec_stop = 1'b0;

        // R6 image with bit2 set
        ee_pulse(1'b1, 32'h0000_0001, 32'h0F0F_0F04);
        chk("R6 image sets done", misc_rd, 32'h0F0F_0F04);

        // R7 fallback, memory absent
        do_reset(1'b0);
        loc_master_present = 1'b0;
        ee_pulse(1'b0, 32'h0, 32'hDEAD_BEEF);
        chk("R7 fallback absent", misc_rd, MRST | 32'h4);

        // R7 fallback, blank memory
        do_reset(1'b1);
        ee_pulse(1'b1, 32'hFFFF_FFFF, 32'hDEAD_BEEF);
        chk("R7 fallback blank", misc_rd, MRST | 32'h4);
        acc_req = 1'b1;
        tick();
        acc_req = 1'b0;
        chk("R9 no retry after done", pins(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule